// File: doc/BRIEF.md
# Virtual Address Translation Cache

This block turns a virtual address into a physical address. The upper bits of the address form the page number and the lower `OFF_W` bits form the offset within the page. The page number is compared against every slot of a small, fully associative cache of page table entries. On a hit, the entry's frame number takes the place of the page number and the offset is passed through unchanged. Each cached entry carries permission flags: present, read-only, execute-permitted and supervisor-only. An access that breaks one of these flags produces a coded fault. An access with no matching entry produces a miss. Each entry also holds an accessed flag and a modified flag, and the block updates them on successful hits.

Out of reset the block runs in physical addressing mode. In that mode every address passes through unchanged and no checks are made. Software moves the block into translating mode by writing the mode control bit. An external agent fills entries through a plain write port, and a round-robin pointer picks the slot each write replaces. A pulse on the page-table-base-written pin, which happens on a context switch, empties the whole cache.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream, one cycle after acceptance. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and no new request is taken.

Top module: `tlb_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0, the block is in physical mode, and the cache is empty: a translating-mode lookup of any address returns a miss until an entry has been written.
- R2: In physical mode (mode bit 0) the response address equals the request address. `rsp_miss`, `rsp_fault`, `rsp_accessed` and `rsp_modified` are all 0, whatever the write, fetch and user inputs are and whatever the cache holds.
- R3: In translating mode, a hit that passes every check returns `{frame number, request[OFF_W-1:0]}` with `rsp_miss` and `rsp_fault` both 0. The page number is `req_vaddr[ADDR_W-1:OFF_W]`, and `OFF_W` defaults to 20.
- R4: In translating mode, a lookup that matches no filled slot returns `rsp_miss`=1, `rsp_fault`=0 and `rsp_paddr`=0.
- R5: A hit that breaks a permission returns `rsp_fault`=1 and `rsp_paddr`=0, with `rsp_fcode` chosen by the first rule that applies in this order: entry not present gives 0; a write to a read-only page gives 1; a fetch from a page without execute permission gives 2; a user access (`req_user`=1) to a supervisor-only page gives 3.
- R6: A hit with no fault sets the entry's accessed flag, and also sets its modified flag if `req_write`=1. The response reports both flags as they stand after the update. The flags persist until the slot is refilled or the cache is flushed. Faults and misses report 0 for both flags and change neither.
- R7: A `ptbase_wr` pulse empties every slot, so later lookups miss. A fill in the same cycle as a flush has no effect.
- R8: Each fill writes the slot under a round-robin pointer, which then advances. After `ENTRIES`+1 fills of distinct pages, the first page filled misses and the others hit.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. A response appears the cycle after acceptance. While stalled, all response outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_en | input | 1 | Write strobe for the mode bit |
| mode_virt | input | 1 | Mode value written: 1 translating, 0 physical |
| ptbase_wr | input | 1 | Page-table base written; flushes the cache |
| fill_en | input | 1 | Write one entry at the round-robin slot |
| fill_vpn | input | ADDR_W-OFF_W | Page number of the entry |
| fill_pfn | input | ADDR_W-OFF_W | Frame number of the entry |
| fill_present | input | 1 | Entry maps a frame |
| fill_ro | input | 1 | Page is read-only |
| fill_exec | input | 1 | Fetches permitted |
| fill_sup | input | 1 | Supervisor-only page |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_vaddr | input | ADDR_W | Address to translate |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | ADDR_W | Physical address, 0 on miss or fault |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Permission or present fault |
| rsp_fcode | output | 2 | Fault code |
| rsp_accessed | output | 1 | Accessed flag of the hit entry |
| rsp_modified | output | 1 | Modified flag of the hit entry |

## Verification
Four entries with contrasting flags are tried with reads, writes, fetches, user and supervisor accesses, and combined write-plus-fetch accesses. This separates correct frame substitution from the fault codes and shows the fault priority wherever two rules apply at once. Repeated hits on one page show whether the modified flag is stored or only echoed, and the same addresses are sent in physical mode to show that bypass ignores the cache. Flush, flush coinciding with a fill, a run of nine fills, and a stalled output stream each address one corner: emptying, ignored fill, slot reuse order, and holding under back-pressure.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    FLT_ABSENT   = 2'd0,
    FLT_READONLY = 2'd1,
    FLT_NOEXEC   = 2'd2,
    FLT_SUPER    = 2'd3
  } flt_code_e;

  typedef struct packed {
    logic present;
    logic ro;
    logic exec;
    logic sup;
  } pte_perm_t;

endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  pte_perm_t   perm,
  input  logic        acc_write,
  input  logic        acc_fetch,
  input  logic        acc_user,
  output logic        fault,
  output flt_code_e   code
);
  always_comb begin
    fault = 1'b1;
    code  = FLT_ABSENT;
    if (!perm.present)                code = FLT_ABSENT;
    else if (acc_write && perm.ro)    code = FLT_READONLY;
    else if (acc_fetch && !perm.exec) code = FLT_NOEXEC;
    else if (acc_user && perm.sup)    code = FLT_SUPER;
    else                              fault = 1'b0;
  end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_pfn,
  input  pte_perm_t        fill_perm,
  input  logic [VPN_W-1:0] lkp_vpn,
  input  logic             upd_en,
  input  logic             upd_write,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [VPN_W-1:0] hit_pfn,
  output pte_perm_t        hit_perm,
  output logic             hit_mod
);
  logic [ENTRIES-1:0] used_q, acc_q, mod_q, match;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [VPN_W-1:0]   pfn_q  [ENTRIES];
  pte_perm_t          perm_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_q[g] <= 1'b0;
        acc_q[g]  <= 1'b0;
        mod_q[g]  <= 1'b0;
        vpn_q[g]  <= '0;
        pfn_q[g]  <= '0;
        perm_q[g] <= '0;
      end else if (flush) begin
        used_q[g] <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(g)) begin
        used_q[g] <= 1'b1;
        acc_q[g]  <= 1'b0;
        mod_q[g]  <= 1'b0;
        vpn_q[g]  <= fill_vpn;
        pfn_q[g]  <= fill_pfn;
        perm_q[g] <= fill_perm;
      end else if (upd_en && hit_idx == IDX_W'(g)) begin
        acc_q[g] <= 1'b1;
        if (upd_write) mod_q[g] <= 1'b1;
      end
    end
    assign match[g] = used_q[g] && (vpn_q[g] == lkp_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign hit      = |match;
  assign hit_pfn  = pfn_q[hit_idx];
  assign hit_perm = perm_q[hit_idx];
  assign hit_mod  = mod_q[hit_idx];
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 20,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_en,
  input  logic              mode_virt,
  input  logic              ptbase_wr,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [VPN_W-1:0]  fill_pfn,
  input  logic              fill_present,
  input  logic              fill_ro,
  input  logic              fill_exec,
  input  logic              fill_sup,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [1:0]        rsp_fcode,
  output logic              rsp_accessed,
  output logic              rsp_modified
);
  logic             virt_q, accept, hit, hit_mod, perm_fault, upd_en;
  logic [IDX_W-1:0] rr_ptr, hit_idx;
  logic [VPN_W-1:0] hit_pfn;
  pte_perm_t        hit_perm, fill_perm;
  flt_code_e        perm_code;
  logic             fill_take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign fill_take = fill_en && !ptbase_wr;
  assign fill_perm = '{present: fill_present, ro: fill_ro, exec: fill_exec, sup: fill_sup};

  always_ff @(posedge clk) begin
    if (!rst_n)          virt_q <= 1'b0;
    else if (mode_wr_en) virt_q <= mode_virt;
  end

  tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(fill_take), .ptr(rr_ptr)
  );

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .flush(ptbase_wr),
    .fill_en(fill_take), .fill_idx(rr_ptr), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .lkp_vpn(req_vaddr[ADDR_W-1:OFF_W]),
    .upd_en(upd_en), .upd_write(req_write),
    .hit(hit), .hit_idx(hit_idx), .hit_pfn(hit_pfn),
    .hit_perm(hit_perm), .hit_mod(hit_mod)
  );

  tlb_perm_check u_perm (
    .perm(hit_perm), .acc_write(req_write), .acc_fetch(req_fetch),
    .acc_user(req_user), .fault(perm_fault), .code(perm_code)
  );

  assign upd_en = accept && virt_q && hit && !perm_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_miss     <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_fcode    <= '0;
      rsp_accessed <= 1'b0;
      rsp_modified <= 1'b0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_paddr    <= '0;
      rsp_miss     <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_fcode    <= '0;
      rsp_accessed <= 1'b0;
      rsp_modified <= 1'b0;
      if (!virt_q) begin
        rsp_paddr <= req_vaddr;
      end else if (!hit) begin
        rsp_miss <= 1'b1;
      end else if (perm_fault) begin
        rsp_fault <= 1'b1;
        rsp_fcode <= perm_code;
      end else begin
        rsp_paddr    <= {hit_pfn, req_vaddr[OFF_W-1:0]};
        rsp_accessed <= 1'b1;
        rsp_modified <= hit_mod || req_write;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              virt_q,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_miss,
  input logic              rsp_fault,
  input logic              rsp_accessed,
  input logic              rsp_modified
);
  AST_PHYS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !virt_q) |=> (rsp_paddr == $past(req_vaddr) && !rsp_miss && !rsp_fault)); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_miss || rsp_fault || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R3
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (!rsp_fault && rsp_paddr == '0)); // R4
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_accessed)); // R5
  AST_MOD_NEEDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_modified) |-> rsp_accessed); // R6
  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_miss) && $stable(rsp_fault))); // R9
endmodule

bind tlb_xlate tlb_xlate_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .virt_q(virt_q),
  .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
  .rsp_accessed(rsp_accessed), .rsp_modified(rsp_modified)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        mode_wr_en = 0, mode_virt = 0, ptbase_wr = 0, fill_en = 0;
  logic [11:0] fill_vpn = 0, fill_pfn = 0;
  logic        fill_present = 0, fill_ro = 0, fill_exec = 0, fill_sup = 0;
  logic        req_valid = 0, req_write = 0, req_fetch = 0, req_user = 0, rsp_ready = 1;
  logic [31:0] req_vaddr = 0;
  logic        req_ready, rsp_valid, rsp_miss, rsp_fault, rsp_accessed, rsp_modified;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fcode;

  int tests = 0, fails = 0;

  tlb_xlate i_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_virt(mode_virt),
    .ptbase_wr(ptbase_wr), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_present(fill_present), .fill_ro(fill_ro), .fill_exec(fill_exec), .fill_sup(fill_sup),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_fcode(rsp_fcode),
    .rsp_accessed(rsp_accessed), .rsp_modified(rsp_modified)
  );

  typedef struct packed {
    logic [31:0] va;
    logic w, f, u;
    logic miss, flt;
    logic [1:0] code;
    logic [31:0] pa;
    logic acc, mod;
    logic [3:0] req;
  } vec_t;

  // Entries: 0x001 rw+exec user, 0x002 ro no-exec user, 0x003 rw+exec supervisor, 0x004 not present
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h00123456, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0A123456, 1'b1, 1'b0, 4'd3}, // R3 read
    '{32'h001FFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0A1FFFFF, 1'b1, 1'b0, 4'd3}, // R3 fetch, max offset
    '{32'h00100000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0A100000, 1'b1, 1'b1, 4'd6}, // R6 write sets modified
    '{32'h00200010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0B200010, 1'b1, 1'b0, 4'd3}, // R3 read of ro page
    '{32'h00200010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 32'h00000000, 1'b0, 1'b0, 4'd5}, // R5 write ro
    '{32'h00200000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 32'h00000000, 1'b0, 1'b0, 4'd5}, // R5 fetch no-exec
    '{32'h00300000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 32'h00000000, 1'b0, 1'b0, 4'd5}, // R5 user to supervisor
    '{32'h00300000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0C300000, 1'b1, 1'b0, 4'd3}, // R3 supervisor ok
    '{32'h00400000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 32'h00000000, 1'b0, 1'b0, 4'd5}, // R5 not present
    '{32'h05500000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 32'h00000000, 1'b0, 1'b0, 4'd4}, // R4 miss
    '{32'h00300004, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 32'h00000000, 1'b0, 1'b0, 4'd5}, // R5 user write supervisor
    '{32'h00200000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 32'h00000000, 1'b0, 1'b0, 4'd5}, // R5 priority ro over noexec
    '{32'h00400000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 32'h00000000, 1'b0, 1'b0, 4'd5}, // R5 priority absent first
    '{32'h00100000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0A100000, 1'b1, 1'b1, 4'd6}, // R6 modified persists
    '{32'hFFF00001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h00000000, 1'b0, 1'b0, 4'd4}  // R4 top page miss
  };

  task automatic check(input string tag, input logic ok, input string act, input string exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic check_rsp(input string tag, input logic m, input logic f, input logic [1:0] c,
                           input logic [31:0] pa, input logic a, input logic md);
    check(tag, rsp_valid && rsp_miss == m && rsp_fault == f && (!f || rsp_fcode == c) &&
               rsp_paddr == pa && rsp_accessed == a && rsp_modified == md,
          $sformatf("v%0d m%0d f%0d c%0d pa=%h a%0d md%0d", rsp_valid, rsp_miss, rsp_fault, rsp_fcode, rsp_paddr, rsp_accessed, rsp_modified),
          $sformatf("v1 m%0d f%0d c%0d pa=%h a%0d md%0d", m, f, c, pa, a, md));
  endtask

  task automatic lookup(input logic [31:0] va, input logic w, input logic f, input logic u);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = w; req_fetch = f; req_user = u;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic fill(input logic [11:0] vpn, input logic [11:0] pfn,
                      input logic p, input logic ro, input logic x, input logic s);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_pfn = pfn;
    fill_present = p; fill_ro = ro; fill_exec = x; fill_sup = s;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk);
    mode_wr_en = 1; mode_virt = v;
    @(negedge clk);
    mode_wr_en = 0;
  endtask

  task automatic flush();
    @(negedge clk);
    ptbase_wr = 1;
    @(negedge clk);
    ptbase_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", rsp_valid == 0 && req_ready == 1,
          $sformatf("%0d", rsp_valid), "0");
    rst_n = 1;
    // R1 physical out of reset; R2 permission inputs ignored
    lookup(32'h00123456, 1, 1, 1);
    check_rsp("R1 R2 physical after reset", 0, 0, 0, 32'h00123456, 0, 0);
    set_mode(1);
    lookup(32'h00123456, 0, 0, 1);
    check_rsp("R1 empty cache miss", 1, 0, 0, 32'h0, 0, 0);

    fill(12'h001, 12'h0A1, 1, 0, 1, 0);
    fill(12'h002, 12'h0B2, 1, 1, 0, 0);
    fill(12'h003, 12'h0C3, 1, 0, 1, 1);
    fill(12'h004, 12'h0D4, 0, 1, 1, 0);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].va, VECS[i].w, VECS[i].f, VECS[i].u);
      check_rsp($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].miss, VECS[i].flt,
                VECS[i].code, VECS[i].pa, VECS[i].acc, VECS[i].mod);
    end

    // R2: physical mode bypasses a filled cache, even faulting/missing addresses
    set_mode(0);
    lookup(32'h00200010, 1, 1, 1);
    check_rsp("R2 bypass ro page", 0, 0, 0, 32'h00200010, 0, 0);
    lookup(32'h05500000, 0, 0, 1);
    check_rsp("R2 bypass unmapped", 0, 0, 0, 32'h05500000, 0, 0);
    set_mode(1);

    // R9: stall holds the response and blocks new requests
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vaddr = 32'h00100ABC; req_write = 0; req_fetch = 0; req_user = 1;
    @(negedge clk);
    req_vaddr = 32'h00300000; req_user = 0;
    repeat (2) @(negedge clk);
    check("R9 ready low while stalled", req_ready == 0, $sformatf("%0d", req_ready), "0");
    check_rsp("R9 held response", 0, 0, 0, 32'h0A100ABC, 1, 1);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check_rsp("R9 second request after release", 0, 0, 0, 32'h0C300000, 1, 0);
    @(negedge clk);
    check("R9 response drained", rsp_valid == 0, $sformatf("%0d", rsp_valid), "0");

    // R7: flush empties cache
    flush();
    lookup(32'h00123456, 0, 0, 1);
    check_rsp("R7 miss after flush", 1, 0, 0, 32'h0, 0, 0);
    @(negedge clk);
    ptbase_wr = 1; fill_en = 1; fill_vpn = 12'h300; fill_pfn = 12'h777;
    fill_present = 1; fill_ro = 0; fill_exec = 1; fill_sup = 0;
    @(negedge clk);
    ptbase_wr = 0; fill_en = 0;
    lookup(32'h30000000, 0, 0, 1);
    check_rsp("R7 fill with flush ignored", 1, 0, 0, 32'h0, 0, 0);

    // R8: nine fills over eight slots evict the first
    for (int k = 0; k < 9; k++) fill(12'h100 + 12'(k), 12'h200 + 12'(k), 1, 0, 1, 0);
    lookup(32'h10000000, 0, 0, 1);
    check_rsp("R8 oldest evicted", 1, 0, 0, 32'h0, 0, 0);
    lookup(32'h10155555, 0, 0, 1);
    check_rsp("R8 second kept", 0, 0, 0, 32'h20155555, 1, 0);
    lookup(32'h10800001, 1, 0, 1);
    check_rsp("R8 newest in reused slot", 0, 0, 0, 32'h20800001, 1, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule